// File: doc/BRIEF.md
# Serial EEPROM Status Register and Write Guard

This block keeps the status byte of a serial EEPROM and rules on every write request. It holds a write enable latch, two bits that select a protected share of the array, and a bit that arms the hardware write-protect pin. It also passes the busy flag of the write controller into the status byte, so that a status read shows whether a write is still in progress.

The serial front-end sends one-cycle command strobes. Each strobe fires when chip select rises after a complete, valid sequence. The strobes are write-enable, write-disable, status write (with its data byte) and array write (with its target address). The block returns the status byte for status reads. It also gives two permits: one for status writes, and one for the address now on `wr_addr`. The front-end uses the second permit to gate each byte of a page write.

The non-volatile bits are plain registers. The power-up reset clears them. The soft reset does not touch them.

Top module: `eeprom_wp_status`

## Requirements
- R1: After the power-up reset (`rst_n` low), the status byte reads 0x00.
- R2: The status byte layout is bit 7 = protect-pin enable, bits 6:4 = 0, bits 3:2 = quarter-select code, bit 1 = write enable latch, bit 0 = `busy` in the same cycle.
- R3: A `cmd_wren` pulse sets the write enable latch in the next cycle, and a `cmd_wrdi` pulse clears it. If both pulse in the same cycle, `cmd_wrdi` wins.
- R4: `srst` clears the write enable latch in the next cycle and leaves bits 7 and 3:2 unchanged.
- R5: A `cmd_wrsr` pulse while the latch is 0 changes no status bit.
- R6: While bit 7 is 1 and `wp_pin` is 0, a `cmd_wrsr` pulse changes no status bit, so the latch stays set. While bit 7 is 0, the level of `wp_pin` has no effect.
- R7: An accepted `cmd_wrsr` copies `wrsr_data` bits 7, 3 and 2 into status bits 7, 3 and 2. It ignores the other data bits and clears the latch in the next cycle.
- R8: The code in bits 3:2 protects part of the array. Code 0 protects nothing. Code 1 protects the top quarter, 0x300–0x3FF. Code 2 protects the top half, 0x200–0x3FF. Code 3 protects every address. `array_write_ok` is 0 for a protected `wr_addr`.
- R9: `array_write_ok` is 1 only when the latch is 1 and `wr_addr` is unprotected. A `cmd_write` pulse with the permit set clears the latch. A `cmd_write` pulse to a protected address leaves the latch set.
- R10: While `busy` is 1, the command strobes change no status bit.
- R11: `sr_write_ok` is 1 exactly when the latch is 1 and either bit 7 is 0 or `wp_pin` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-up reset, asynchronous, active low |
| srst | input | 1 | Soft reset, synchronous; clears only the latch |
| busy | input | 1 | Internal write in progress |
| wp_pin | input | 1 | Write-protect pin level |
| cmd_wren | input | 1 | Write-enable command completed |
| cmd_wrdi | input | 1 | Write-disable command completed |
| cmd_wrsr | input | 1 | Status write sequence completed |
| wrsr_data | input | 8 | Data byte of the status write |
| cmd_write | input | 1 | Array write sequence completed |
| wr_addr | input | ADDR_W | Target byte address of the array write |
| status_byte | output | 8 | Status byte returned by a status read |
| sr_write_ok | output | 1 | Status write would be accepted |
| array_write_ok | output | 1 | Write to `wr_addr` would be accepted |

## Verification
The assertions check the following on every cycle:
- the zero bits and the busy mirror in the status byte;
- the latch setting after an idle write-enable;
- refused status writes leaving the byte unchanged;
- the array permit never being raised while the latch is clear or the whole array is protected.

Some behaviour only the bench scenarios can show. The bench sweeps every address under each of the four protection codes. It walks through the full matrix of protect-pin enable and pin level. It checks that the soft reset keeps the non-volatile bits, and that strobes are ignored while a write is in progress.

// File: rtl/eeprom_wp_pkg.sv
package eeprom_wp_pkg;
  localparam int STAT_W = 8;
  localparam int BIT_WIP  = 0;
  localparam int BIT_WEL  = 1;
  localparam int BIT_BP0  = 2;
  localparam int BIT_BP1  = 3;
  localparam int BIT_WPEN = 7;

  typedef enum logic [1:0] {
    PROT_NONE    = 2'd0,
    PROT_QUARTER = 2'd1,
    PROT_HALF    = 2'd2,
    PROT_ALL     = 2'd3
  } prot_code_e;

  typedef struct packed {
    logic       wpen;
    prot_code_e bp;
  } nv_bits_t;
endpackage

// File: rtl/eeprom_wel_latch.sv
module eeprom_wel_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic srst,
  input  logic hold,
  input  logic set_req,
  input  logic clr_req,
  output logic wel
);
  logic wel_d;

  always_comb begin
    wel_d = wel;
    if (srst)         wel_d = 1'b0;
    else if (!hold) begin
      if (clr_req)      wel_d = 1'b0;
      else if (set_req) wel_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wel <= 1'b0;
    else        wel <= wel_d;
  end
endmodule

// File: rtl/eeprom_nv_bits.sv
module eeprom_nv_bits
  import eeprom_wp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [STAT_W-1:0] load_data,
  output nv_bits_t          nv
);
  nv_bits_t nv_d;

  always_comb begin
    nv_d = nv;
    if (load_en) begin
      nv_d.wpen = load_data[BIT_WPEN];
      nv_d.bp   = prot_code_e'({load_data[BIT_BP1], load_data[BIT_BP0]});
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) nv <= '{wpen: 1'b0, bp: PROT_NONE};
    else        nv <= nv_d;
  end
endmodule

// File: rtl/eeprom_prot_decode.sv
module eeprom_prot_decode
  import eeprom_wp_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  prot_code_e        bp,
  input  logic [ADDR_W-1:0] addr,
  output logic              protected_hit
);
  localparam int TOP_LSB = ADDR_W - 2;

  logic [1:0] quarter;
  assign quarter = addr[ADDR_W-1:TOP_LSB];

  always_comb begin
    unique case (bp)
      PROT_NONE:    protected_hit = 1'b0;
      PROT_QUARTER: protected_hit = (quarter == 2'b11);
      PROT_HALF:    protected_hit = quarter[1];
      default:      protected_hit = 1'b1;
    endcase
  end
endmodule

// File: rtl/eeprom_wp_status.sv
module eeprom_wp_status
  import eeprom_wp_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              srst,
  input  logic              busy,
  input  logic              wp_pin,
  input  logic              cmd_wren,
  input  logic              cmd_wrdi,
  input  logic              cmd_wrsr,
  input  logic [7:0]        wrsr_data,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        status_byte,
  output logic              sr_write_ok,
  output logic              array_write_ok
);
  logic     wel;
  nv_bits_t nv;
  logic     prot_hit;
  logic     sr_take;
  logic     arr_take;
  logic     sr_load;

  assign sr_write_ok    = wel && (!nv.wpen || wp_pin);
  assign array_write_ok = wel && !prot_hit;

  assign sr_take  = cmd_wrsr && sr_write_ok && !cmd_wrdi && !cmd_wren;
  assign arr_take = cmd_write && array_write_ok && !cmd_wrdi && !cmd_wren && !cmd_wrsr;
  assign sr_load  = sr_take && !busy;

  eeprom_wel_latch u_wel (
    .clk     (clk),
    .rst_n   (rst_n),
    .srst    (srst),
    .hold    (busy),
    .set_req (cmd_wren),
    .clr_req (cmd_wrdi || sr_take || arr_take),
    .wel     (wel)
  );

  eeprom_nv_bits u_nv (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (sr_load),
    .load_data (wrsr_data),
    .nv        (nv)
  );

  eeprom_prot_decode #(.ADDR_W(ADDR_W)) u_dec (
    .bp            (nv.bp),
    .addr          (wr_addr),
    .protected_hit (prot_hit)
  );

  always_comb begin
    status_byte           = '0;
    status_byte[BIT_WPEN] = nv.wpen;
    status_byte[BIT_BP1]  = nv.bp[1];
    status_byte[BIT_BP0]  = nv.bp[0];
    status_byte[BIT_WEL]  = wel;
    status_byte[BIT_WIP]  = busy;
  end
endmodule

// File: rtl/eeprom_wp_status_chk.sv
module eeprom_wp_status_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              srst,
  input logic              busy,
  input logic              wp_pin,
  input logic              cmd_wren,
  input logic              cmd_wrdi,
  input logic              cmd_wrsr,
  input logic              cmd_write,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        status_byte,
  input logic              sr_write_ok,
  input logic              array_write_ok
);
  assert_unused_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    status_byte[6:4] == 3'b000);

  assert_wip_mirror_R2: assert property (@(posedge clk) disable iff (!rst_n)
    status_byte[0] == busy);

  assert_wren_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wren && !cmd_wrdi && !busy && !srst) |=> status_byte[1]);

  assert_srst_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (!status_byte[1] && $stable(status_byte[7:2])));

  assert_locked_refuse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wrsr && status_byte[7] && !wp_pin && !cmd_wren && !cmd_wrdi && !srst)
      |=> $stable(status_byte[7:1]));

  assert_busy_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !srst) |=> $stable(status_byte[7:1]));

  assert_needs_wel_R9: assert property (@(posedge clk) disable iff (!rst_n)
    array_write_ok |-> status_byte[1]);

  assert_all_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (status_byte[3:2] == 2'b11) |-> !array_write_ok);

  assert_sr_permit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sr_write_ok |-> (status_byte[1] && (wp_pin || !status_byte[7])));

  wire unused_ok = &{1'b0, cmd_write, wr_addr};
endmodule

bind eeprom_wp_status eeprom_wp_status_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .srst           (srst),
  .busy           (busy),
  .wp_pin         (wp_pin),
  .cmd_wren       (cmd_wren),
  .cmd_wrdi       (cmd_wrdi),
  .cmd_wrsr       (cmd_wrsr),
  .cmd_write      (cmd_write),
  .wr_addr        (wr_addr),
  .status_byte    (status_byte),
  .sr_write_ok    (sr_write_ok),
  .array_write_ok (array_write_ok)
);

// File: tb/eeprom_wp_status_bench.sv
module eeprom_wp_status_bench;
  localparam int AW = 10;

  logic clk = 1'b0;
  logic rst_n, srst, busy, wp_pin;
  logic cmd_wren, cmd_wrdi, cmd_wrsr, cmd_write;
  logic [7:0] wrsr_data;
  logic [AW-1:0] wr_addr;
  logic [7:0] status_byte;
  logic sr_write_ok, array_write_ok;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  eeprom_wp_status #(.ADDR_W(AW)) u_eeprom_wp_status (
    .clk(clk), .rst_n(rst_n), .srst(srst), .busy(busy), .wp_pin(wp_pin),
    .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi), .cmd_wrsr(cmd_wrsr),
    .wrsr_data(wrsr_data), .cmd_write(cmd_write), .wr_addr(wr_addr),
    .status_byte(status_byte), .sr_write_ok(sr_write_ok),
    .array_write_ok(array_write_ok)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // Strobe driven at negedge, held over one posedge, sampled at the next negedge.
  task automatic pulse(input int which, input logic [7:0] d);
    @(negedge clk);
    wrsr_data = d;
    cmd_wren  = (which == 0);
    cmd_wrdi  = (which == 1);
    cmd_wrsr  = (which == 2);
    cmd_write = (which == 3);
    srst      = (which == 4);
    @(negedge clk);
    {cmd_wren, cmd_wrdi, cmd_wrsr, cmd_write, srst} = '0;
  endtask

  function automatic logic prot(input int bp, input int a);
    case (bp)
      0: return 1'b0;
      1: return a >= 768;
      2: return a >= 512;
      default: return 1'b1;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 0; srst = 0; busy = 0; wp_pin = 1;
    {cmd_wren, cmd_wrdi, cmd_wrsr, cmd_write} = '0;
    wrsr_data = '0; wr_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset", status_byte, 8'h00);
    busy = 1; #1;
    check("R2 wip", status_byte, 8'h01);
    busy = 0;
    pulse(2, 8'hFF);
    check("R5 no wel", status_byte, 8'h00);
    pulse(0, 0);
    check("R3 wren", status_byte, 8'h02);
    pulse(1, 0);
    check("R3 wrdi", status_byte, 8'h00);
    pulse(0, 0);
    pulse(2, 8'hFF);
    check("R7 wrsr", status_byte, 8'h8C);
    wp_pin = 0;
    pulse(0, 0);
    check("R11 locked", {7'd0, sr_write_ok}, 8'h00);
    pulse(2, 8'h00);
    check("R6 locked", status_byte, 8'h8E);
    wp_pin = 1; #1;
    check("R11 pin high", {7'd0, sr_write_ok}, 8'h01);
    pulse(2, 8'h70);
    check("R7 mask", status_byte, 8'h00);
    wp_pin = 0;
    pulse(0, 0);
    check("R11 wpen0", {7'd0, sr_write_ok}, 8'h01);
    pulse(2, 8'h04);
    check("R6 pin ignored", status_byte, 8'h04);
    pulse(0, 0);
    pulse(4, 0);
    check("R4 srst", status_byte, 8'h04);
    pulse(0, 0);
    pulse(1, 0);
    check("R3 wrdi", status_byte, 8'h04);
    // R8 / R9 sweep over all codes and addresses
    for (int bp = 0; bp < 4; bp++) begin
      pulse(0, 0);
      pulse(2, 8'(bp << 2));
      for (int a = 0; a < 1024; a += 37) begin
        wr_addr = AW'(a); #1;
        check("R9 wel0", {7'd0, array_write_ok}, 8'h00);
      end
      pulse(0, 0);
      for (int a = 0; a < 1024; a++) begin
        wr_addr = AW'(a); #1;
        check("R8 decode", {7'd0, array_write_ok}, {7'd0, !prot(bp, a)});
      end
    end
    pulse(1, 0);
    pulse(0, 0);
    pulse(2, 8'h04);
    pulse(0, 0);
    wr_addr = 10'h300;
    pulse(3, 0);
    check("R9 protected keeps wel", status_byte, 8'h06);
    wr_addr = 10'h2FF;
    pulse(3, 0);
    check("R9 write clears wel", status_byte, 8'h04);
    busy = 1;
    pulse(0, 0);
    check("R10 busy wren", status_byte, 8'h05);
    busy = 0;
    pulse(0, 0);
    busy = 1;
    pulse(2, 8'h8C);
    check("R10 busy wrsr", status_byte, 8'h07);
    busy = 0;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule